// File: doc/BRIEF.md
# Lockable Raster Timing Generator

The block produces raster video timing from a pixel clock: horizontal and vertical sync, horizontal and vertical blank, and an active-video qualifier. All of these are decoded from a pixel counter and a line counter that walk a programmed raster. Two frame-sync outputs each give a single-clock pulse at their own pixel/line position, so two downstream processors can be started at different points in the frame. A frame-start interrupt pulse lets software align with the raster.

The generator either free-runs or locks its phase to one of three external references chosen by `ref_sel_i`: a frame-sync pulse, a vertical sync or a vertical blank. A rising edge of the chosen reference moves the counters. With the vertical references, the frame starts on the edge itself. With the frame-sync reference, the frame starts a programmed number of lines and pixels after the edge. Because blank is decoded from the counters, blank outputs exist even when the reference carries only syncs. The polarity of each sync and blank output is programmable.

All settings are written through a register-style port into staging registers. Staged values become active together at the next frame start, so the raster, polarity and frame-sync positions can change at run time without tearing a frame.

Top module: `raster_timing_gen`

## Requirements
- R1: Pixel counter h runs 0..H-1 and line counter v advances once per line and runs 0..V-1. `irq_o` is high for exactly the one clock in which (h,v)=(0,0). The frame period is H*V clocks. Reset defaults: H=12, V=8.
- R2: `hblank_o` is asserted while h >= active width (address 1). `vblank_o` is asserted while v >= active height (address 5). `active_o` is high only when neither blank is asserted.
- R3: `hsync_o` is asserted while hsync start (address 2) <= h < hsync end (address 3). `vsync_o` is asserted while vsync start (address 6) <= v < vsync end (address 7).
- R4: Polarity register (address 14): bit 0 inverts hsync, bit 1 vsync, bit 2 hblank, bit 3 vblank. `active_o` is never inverted.
- R5: `fsync_o[0]` is high for one clock when (h,v) equals (address 8, address 9). `fsync_o[1]` does the same for (address 10, address 11).
- R6: A write (we, addr, data) updates a staging register. Staged values become active together on the clock edge at which the counters enter (0,0), and not before.
- R7: `ref_sel_i` encoding: 0 = frame-sync input, 1 = vertical-sync input, 2 = vertical-blank input, 3 = free-run. The selected value is registered each clock. A reload happens at the edge where the selected value is 1 and its registered copy is 0.
- R8: With `ref_sel_i` 1 or 2, a reload puts the counters at (0,0). With `ref_sel_i` 0, a reload puts them at the position from which (0,0) is reached after L*H+P clocks. P is taken from address 12 and must be < H; L is taken from address 13 and must be < V.
- R9: Edges on unselected references have no effect. A selected reference held high produces no further reload, and the counters keep free-running.
- R10: After reset the counters are at (0,0) and every register holds its default (address order 0..14: 12,8,9,10,8,5,6,7,1,0,4,2,0,0,0).
- R11: Register addresses 0..14 are, in order: H, active width, hsync start, hsync end, V, active height, vsync start, vsync end, fsync0 pixel, fsync0 line, fsync1 pixel, fsync1 line, lock pixel offset, lock line offset, polarity. A write to address 15 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register address |
| cfg_wdata_i | input | CW | Configuration write data |
| ref_sel_i | input | 2 | Lock reference select |
| ref_fsync_i | input | 1 | External frame-sync reference |
| ref_vsync_i | input | 1 | External vertical-sync reference |
| ref_vblank_i | input | 1 | External vertical-blank reference |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blank |
| vblank_o | output | 1 | Vertical blank |
| active_o | output | 1 | Active video |
| fsync_o | output | 2 | Frame-sync pulses for two processors |
| irq_o | output | 1 | Frame-start interrupt pulse |

## Verification
All outputs are decoded without a register from the counter and active-configuration flops. Each output therefore reflects the counter position that a rising edge has just loaded, and the bench compares its model with the outputs at every falling edge. A reference edge driven at a falling edge is sampled at the next rising edge, so with a vertical reference the interrupt is due at the very next falling edge. With the frame-sync reference and offset (P,L), it is due L*H+P falling edges after that. A configuration write is due at the first frame start after it, which the bench confirms by measuring irq-to-irq intervals in rising edges.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int NUM_REGS = 15;
  localparam int NUM_FS   = 2;
  localparam int I_HTOT   = 0;
  localparam int I_HACT   = 1;
  localparam int I_HS0    = 2;
  localparam int I_HS1    = 3;
  localparam int I_VTOT   = 4;
  localparam int I_VACT   = 5;
  localparam int I_VS0    = 6;
  localparam int I_VS1    = 7;
  localparam int I_FS_PX  = 8;   // fsync i pixel at 8+2i, line at 9+2i
  localparam int I_LK_PX  = 12;
  localparam int I_LK_LN  = 13;
  localparam int I_POL    = 14;
  localparam logic [1:0] REF_FSYNC  = 2'd0;
  localparam logic [1:0] REF_VSYNC  = 2'd1;
  localparam logic [1:0] REF_VBLANK = 2'd2;
  localparam logic [1:0] REF_NONE   = 2'd3;
endpackage

// File: rtl/rtg_cfg_regs.sv
module rtg_cfg_regs import rtg_pkg::*; #(
  parameter int CW = 12,
  parameter logic [NUM_REGS*CW-1:0] RST_VAL = '0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [3:0]             addr_i,
  input  logic [CW-1:0]          wdata_i,
  input  logic                   commit_i,
  output logic [NUM_REGS*CW-1:0] act_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [CW-1:0] stage_q, act_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= RST_VAL[i*CW +: CW];
        act_q   <= RST_VAL[i*CW +: CW];
      end else begin
        if (commit_i) act_q <= stage_q;
        if (we_i && addr_i == 4'(i)) stage_q <= wdata_i;
      end
    end
    assign act_o[i*CW +: CW] = act_q;
  end
endmodule

// File: rtl/rtg_lock.sv
module rtg_lock import rtg_pkg::*; #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  input  logic          fsync_i,
  input  logic          vsync_i,
  input  logic          vblank_i,
  input  logic [CW-1:0] h_tot_i,
  input  logic [CW-1:0] v_tot_i,
  input  logic [CW-1:0] off_px_i,
  input  logic [CW-1:0] off_ln_i,
  output logic          reload_o,
  output logic [CW-1:0] rl_h_o,
  output logic [CW-1:0] rl_v_o
);
  logic          ref_val, ref_q;
  logic [CW-1:0] px, ln;

  always_comb begin
    case (sel_i)
      REF_FSYNC:  ref_val = fsync_i;
      REF_VSYNC:  ref_val = vsync_i;
      REF_VBLANK: ref_val = vblank_i;
      default:    ref_val = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= ref_val;
  end

  assign reload_o = ref_val & ~ref_q;
  assign px = (sel_i == REF_FSYNC) ? off_px_i : '0;
  assign ln = (sel_i == REF_FSYNC) ? off_ln_i : '0;

  // position that reaches (0,0) after ln*H+px clocks
  always_comb begin
    if (px == '0) begin
      rl_h_o = '0;
      rl_v_o = (ln == '0) ? '0 : v_tot_i - ln;
    end else begin
      rl_h_o = h_tot_i - px;
      rl_v_o = v_tot_i - ln - CW'(1);
    end
  end
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] h_tot_i,
  input  logic [CW-1:0] v_tot_i,
  input  logic          reload_i,
  input  logic [CW-1:0] rl_h_i,
  input  logic [CW-1:0] rl_v_i,
  output logic [CW-1:0] h_o,
  output logic [CW-1:0] v_o,
  output logic          frame_next_o
);
  logic [CW-1:0] h_q, v_q, h_d, v_d;
  logic          h_last, v_last;

  assign h_last = h_q >= h_tot_i - CW'(1);
  assign v_last = v_q >= v_tot_i - CW'(1);

  always_comb begin
    if (reload_i) begin
      h_d = rl_h_i;
      v_d = rl_v_i;
    end else if (h_last) begin
      h_d = '0;
      v_d = v_last ? '0 : v_q + CW'(1);
    end else begin
      h_d = h_q + CW'(1);
      v_d = v_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign h_o          = h_q;
  assign v_o          = v_q;
  assign frame_next_o = (h_d == '0) && (v_d == '0);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen import rtg_pkg::*; #(
  parameter int CW         = 12,
  parameter int DEF_H_TOT  = 12,
  parameter int DEF_H_ACT  = 8,
  parameter int DEF_HS0    = 9,
  parameter int DEF_HS1    = 10,
  parameter int DEF_V_TOT  = 8,
  parameter int DEF_V_ACT  = 5,
  parameter int DEF_VS0    = 6,
  parameter int DEF_VS1    = 7,
  parameter int DEF_FS0_PX = 1,
  parameter int DEF_FS0_LN = 0,
  parameter int DEF_FS1_PX = 4,
  parameter int DEF_FS1_LN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_addr_i,
  input  logic [CW-1:0]     cfg_wdata_i,
  input  logic [1:0]        ref_sel_i,
  input  logic              ref_fsync_i,
  input  logic              ref_vsync_i,
  input  logic              ref_vblank_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              hblank_o,
  output logic              vblank_o,
  output logic              active_o,
  output logic [NUM_FS-1:0] fsync_o,
  output logic              irq_o
);
  localparam logic [NUM_REGS*CW-1:0] RST_VAL = {
    CW'(0), CW'(0), CW'(0), CW'(DEF_FS1_LN), CW'(DEF_FS1_PX),
    CW'(DEF_FS0_LN), CW'(DEF_FS0_PX), CW'(DEF_VS1), CW'(DEF_VS0),
    CW'(DEF_V_ACT), CW'(DEF_V_TOT), CW'(DEF_HS1), CW'(DEF_HS0),
    CW'(DEF_H_ACT), CW'(DEF_H_TOT)};

  logic [NUM_REGS*CW-1:0] act_cfg;
  logic [CW-1:0] h_cnt, v_cnt, rl_h, rl_v;
  logic          reload, frame_next;
  logic [3:0]    pol;
  logic          hb, vb, hs, vs;

  function automatic logic [CW-1:0] fld(input int idx, input logic [NUM_REGS*CW-1:0] v);
    return v[idx*CW +: CW];
  endfunction

  rtg_cfg_regs #(.CW(CW), .RST_VAL(RST_VAL)) u_cfg (
    .clk_i, .rst_ni,
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .commit_i (frame_next),
    .act_o    (act_cfg)
  );

  rtg_lock #(.CW(CW)) u_lock (
    .clk_i, .rst_ni,
    .sel_i    (ref_sel_i),
    .fsync_i  (ref_fsync_i),
    .vsync_i  (ref_vsync_i),
    .vblank_i (ref_vblank_i),
    .h_tot_i  (fld(I_HTOT, act_cfg)),
    .v_tot_i  (fld(I_VTOT, act_cfg)),
    .off_px_i (fld(I_LK_PX, act_cfg)),
    .off_ln_i (fld(I_LK_LN, act_cfg)),
    .reload_o (reload),
    .rl_h_o   (rl_h),
    .rl_v_o   (rl_v)
  );

  rtg_counters #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni,
    .h_tot_i      (fld(I_HTOT, act_cfg)),
    .v_tot_i      (fld(I_VTOT, act_cfg)),
    .reload_i     (reload),
    .rl_h_i       (rl_h),
    .rl_v_i       (rl_v),
    .h_o          (h_cnt),
    .v_o          (v_cnt),
    .frame_next_o (frame_next)
  );

  assign pol = act_cfg[I_POL*CW +: 4];
  assign hb  = h_cnt >= fld(I_HACT, act_cfg);
  assign vb  = v_cnt >= fld(I_VACT, act_cfg);
  assign hs  = (h_cnt >= fld(I_HS0, act_cfg)) && (h_cnt < fld(I_HS1, act_cfg));
  assign vs  = (v_cnt >= fld(I_VS0, act_cfg)) && (v_cnt < fld(I_VS1, act_cfg));

  assign hsync_o  = hs ^ pol[0];
  assign vsync_o  = vs ^ pol[1];
  assign hblank_o = hb ^ pol[2];
  assign vblank_o = vb ^ pol[3];
  assign active_o = ~hb & ~vb;
  assign irq_o    = (h_cnt == '0) && (v_cnt == '0);

  for (genvar i = 0; i < NUM_FS; i++) begin : g_fs
    assign fsync_o[i] = (h_cnt == fld(I_FS_PX + 2*i, act_cfg)) &&
                        (v_cnt == fld(I_FS_PX + 2*i + 1, act_cfg));
  end
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker import rtg_pkg::*; #(
  parameter int CW = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_i,
  input logic [NUM_FS-1:0] fsync_i,
  input logic              active_i,
  input logic              hblank_i,
  input logic              vblank_i,
  input logic [3:0]        pol_i,
  input logic              reload_i,
  input logic [1:0]        sel_i,
  input logic [CW-1:0]     h_i,
  input logic [CW-1:0]     v_i,
  input logic [CW-1:0]     h_tot_i
);
  a_r1_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i && !reload_i |=> !irq_i);

  a_r1_h_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_i < h_tot_i);

  a_r2_active_not_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> !(hblank_i ^ pol_i[2]) && !(vblank_i ^ pol_i[3]));

  a_r5_fsync0_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i[0] && !reload_i |=> !fsync_i[0]);

  a_r5_fsync1_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i[1] && !reload_i |=> !fsync_i[1]);

  a_r8_vref_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i && (sel_i == REF_VSYNC || sel_i == REF_VBLANK) |=> h_i == '0 && v_i == '0);
endmodule

bind raster_timing_gen rtg_checker #(.CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_i    (irq_o),
  .fsync_i  (fsync_o),
  .active_i (active_o),
  .hblank_i (hblank_o),
  .vblank_i (vblank_o),
  .pol_i    (pol),
  .reload_i (reload),
  .sel_i    (ref_sel_i),
  .h_i      (h_cnt),
  .v_i      (v_cnt),
  .h_tot_i  (act_cfg[0 +: CW])
);

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
  localparam int CLK_P = 10;
  localparam int CW    = 12;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [3:0]    cfg_addr_i = '0;
  logic [CW-1:0] cfg_wdata_i = '0;
  logic [1:0]    ref_sel_i = 2'd3;
  logic          ref_fsync_i = 1'b0, ref_vsync_i = 1'b0, ref_vblank_i = 1'b0;
  logic          hsync_o, vsync_o, hblank_o, vblank_o, active_o, irq_o;
  logic [1:0]    fsync_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  raster_timing_gen u0 (.*);

  always #(CLK_P/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int def_cfg[15] = '{12, 8, 9, 10, 8, 5, 6, 7, 1, 0, 4, 2, 0, 0, 0};
  int sh[15], ac[15];
  int m_h, m_v;
  bit m_ref;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_h = 0; m_v = 0; m_ref = 0;
      for (int i = 0; i < 15; i++) begin sh[i] = def_cfg[i]; ac[i] = def_cfg[i]; end
    end else begin
      bit sv;
      int nh, nv, p, l, tot, idx;
      case (ref_sel_i)
        2'd0: sv = ref_fsync_i;
        2'd1: sv = ref_vsync_i;
        2'd2: sv = ref_vblank_i;
        default: sv = 1'b0;
      endcase
      if (sv && !m_ref) begin
        p = (ref_sel_i == 2'd0) ? ac[12] : 0;
        l = (ref_sel_i == 2'd0) ? ac[13] : 0;
        tot = ac[0] * ac[4];
        idx = (tot - (l * ac[0] + p)) % tot;
        nh = idx % ac[0];
        nv = idx / ac[0];
      end else begin
        nh = m_h + 1; nv = m_v;
        if (nh >= ac[0]) begin
          nh = 0; nv = m_v + 1;
          if (nv >= ac[4]) nv = 0;
        end
      end
      m_ref = sv;
      if (nh == 0 && nv == 0)
        for (int i = 0; i < 15; i++) ac[i] = sh[i];
      if (cfg_we_i && cfg_addr_i < 4'd15) sh[cfg_addr_i] = int'(cfg_wdata_i);
      m_h = nh; m_v = nv;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit hb, vb, hs, vs;
      hb = m_h >= ac[1];
      vb = m_v >= ac[5];
      hs = (m_h >= ac[2]) && (m_h < ac[3]);
      vs = (m_v >= ac[6]) && (m_v < ac[7]);
      chk(hsync_o  == (hs ^ ac[14][0]), "R3 R4 hsync",  hsync_o,  hs ^ ac[14][0]);
      chk(vsync_o  == (vs ^ ac[14][1]), "R3 R4 vsync",  vsync_o,  vs ^ ac[14][1]);
      chk(hblank_o == (hb ^ ac[14][2]), "R2 R4 hblank", hblank_o, hb ^ ac[14][2]);
      chk(vblank_o == (vb ^ ac[14][3]), "R2 R4 vblank", vblank_o, vb ^ ac[14][3]);
      chk(active_o == (!hb && !vb),     "R2 active",    active_o, !hb && !vb);
      chk(fsync_o[0] == (m_h == ac[8]  && m_v == ac[9]),  "R5 fsync0", fsync_o[0], m_h == ac[8]  && m_v == ac[9]);
      chk(fsync_o[1] == (m_h == ac[10] && m_v == ac[11]), "R5 fsync1", fsync_o[1], m_h == ac[10] && m_v == ac[11]);
      chk(irq_o == (m_h == 0 && m_v == 0), "R1 R7 R8 irq", irq_o, m_h == 0 && m_v == 0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input int d);
    cfg_we_i = 1'b1; cfg_addr_i = 4'(a); cfg_wdata_i = CW'(d);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!irq_o && n < 1000);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  task summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    int n, t0;
    int new_cfg[16] = '{10, 6, 7, 8, 6, 4, 4, 5, 3, 1, 5, 3, 2, 1, 15, 3};
    idle(3);
    rst_ni = 1'b1;
    // R10 reset state
    chk(irq_o == 1'b1,    "R10 irq at reset", irq_o, 1);
    chk(active_o == 1'b1, "R10 active at reset", active_o, 1);
    chk(hsync_o == 1'b0,  "R10 hsync at reset", hsync_o, 0);
    chk(fsync_o == 2'b00, "R10 fsync at reset", fsync_o, 0);
    // R1 default frame length
    t0 = cyc; wait_irq(n);
    chk(cyc - t0 == 96, "R1 default frame period", cyc - t0, 96);
    // R6 R11 staged writes, address 15 ignored
    t0 = cyc;
    for (int i = 0; i < 16; i++) wr(i, new_cfg[i]);
    wait_irq(n);
    chk(cyc - t0 == 96, "R6 frame not torn", cyc - t0, 96);
    t0 = cyc; wait_irq(n);
    chk(cyc - t0 == 60, "R6 R11 new raster period", cyc - t0, 60);
    // R4 polarity at frame origin: all inactive, all inverted
    chk(hsync_o == 1'b1,  "R4 hsync inverted", hsync_o, 1);
    chk(vsync_o == 1'b1,  "R4 vsync inverted", vsync_o, 1);
    chk(hblank_o == 1'b1, "R4 hblank inverted", hblank_o, 1);
    chk(vblank_o == 1'b1, "R4 vblank inverted", vblank_o, 1);
    chk(active_o == 1'b1, "R4 active not inverted", active_o, 1);
    // R5 frame-sync placement
    n = 0;
    do begin @(negedge clk_i); n++; end while (!fsync_o[0] && n < 100);
    chk(n == 13, "R5 fsync0 position", n, 13);
    do begin @(negedge clk_i); n++; end while (!fsync_o[1] && n < 100);
    chk(n == 35, "R5 fsync1 position", n, 35);
    // R7 R8 lock to vertical sync
    wait_irq(n);
    ref_sel_i = 2'd1;
    idle(5);
    ref_vsync_i = 1'b1;
    wait_irq(n);
    chk(n == 1, "R8 vsync reload to origin", n, 1);
    ref_vsync_i = 1'b0;
    t0 = cyc; wait_irq(n);
    chk(cyc - t0 == 60, "R1 period after vsync lock", cyc - t0, 60);
    // R9 unselected references ignored
    t0 = cyc;
    for (int k = 0; k < 3; k++) begin
      idle(3);
      ref_fsync_i = 1'b1; ref_vblank_i = 1'b1; @(negedge clk_i);
      ref_fsync_i = 1'b0; ref_vblank_i = 1'b0;
    end
    wait_irq(n);
    chk(cyc - t0 == 60, "R9 unselected refs ignored", cyc - t0, 60);
    // R8 frame-sync reference with offset (2 px, 1 line)
    ref_sel_i = 2'd0;
    idle(20);
    ref_fsync_i = 1'b1;
    @(negedge clk_i); n = 1;
    ref_fsync_i = 1'b0;
    while (!irq_o && n < 1000) begin @(negedge clk_i); n++; end
    chk(n == 13, "R8 fsync reload with offset", n, 13);
    // R7 R9 vblank reference held high
    ref_sel_i = 2'd2;
    idle(7);
    ref_vblank_i = 1'b1;
    wait_irq(n);
    chk(n == 1, "R7 vblank reload to origin", n, 1);
    t0 = cyc; wait_irq(n);
    chk(cyc - t0 == 60, "R9 held reference no reload", cyc - t0, 60);
    ref_vblank_i = 1'b0;
    // R7 free-run select ignores all references
    ref_sel_i = 2'd3;
    wait_irq(n);
    t0 = cyc;
    for (int k = 0; k < 4; k++) begin
      idle(2);
      ref_fsync_i = 1'b1; ref_vsync_i = 1'b1; ref_vblank_i = 1'b1; @(negedge clk_i);
      ref_fsync_i = 1'b0; ref_vsync_i = 1'b0; ref_vblank_i = 1'b0;
    end
    wait_irq(n);
    chk(cyc - t0 == 60, "R7 free-run ignores refs", cyc - t0, 60);
    idle(4);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      summary();
      $finish;
    end
  end
endmodule